// File: doc/BRIEF.md
# Common Interrupt Distributor

This block takes a set of shared (common) interrupt inputs and steers each one onto the interrupt lines of a group of cores. Each common interrupt has its own core bitmask, a trigger type (active-high level or rising edge), a delivery policy (fixed to every core in the mask, or load-balanced by rotating through the cores in the mask) and a mask bit. Software configures all of this through a single-cycle command port, and reads state back through a registered readback word.

Rising edges are held in a per-interrupt pending flag until an acknowledge command clears it. Level interrupts follow their input directly. Nothing reaches any core until a global enable command has been issued. Every interrupt leaves reset masked.

Top module: `cidu_top`

## Requirements
- R1: After reset every interrupt is masked, the mode word and the core bitmask of every interrupt read as zero, the global enable is off and every output line is 0.
- R2: Command codes on `cmd_op_i` are: 0 no-op, 1 global enable (takes `cmd_data_i[0]`), 2 set core bitmask, 3 set mode, 4 read mode, 5 set mask, 6 acknowledge, 7 read core bitmask. No output line is driven while the global enable is 0.
- R3: Set-bitmask writes `cmd_data_i[N-1:0]` (bit k = core k) for the interrupt in `cmd_idx_i`. Read-bitmask places that value, zero-extended, on `rd_data_o` from the cycle after the command. `rd_data_o` holds its value until the next read command.
- R4: The mode word holds the delivery policy in bits [1:0] and the trigger type in bit 4 (1 = rising edge, 0 = active-high level). Set-mode overwrites both fields. Read-mode returns the word one cycle later, with bits [3:2] and [31:5] reading as zero.
- R5: Set-mask with `cmd_data_i[0]`=1 masks the interrupt and with 0 unmasks it. A masked interrupt drives no line, but its rising edges are still latched and appear once it is unmasked.
- R6: In level mode, an interrupt is active in every cycle in which its input is 1, with no added latency.
- R7: In edge mode, a 0-to-1 input transition sampled at a clock edge sets the pending flag. The flag is active from the following cycle until an acknowledge for that interrupt. If an acknowledge and a new edge arrive together, the flag stays set.
- R8: Policy 0 (and the codes 2 and 3) delivers an active interrupt to every core set in its bitmask.
- R9: Policy 1 delivers an active interrupt to exactly one core. That core is the next set bitmask bit strictly above the last chosen core, wrapping around. The last chosen core resets to N-1, so the first delivery goes to the lowest set bit. The choice advances when a delivery ends.
- R10: An interrupt whose bitmask is empty reaches no core under either policy.
- R11: Output bit `k*C + i` of `core_irq_o` is the line of core k for interrupt i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 3 | Command code |
| cmd_idx_i | input | IDX_W | Common interrupt index the command acts on |
| cmd_data_i | input | 32 | Command data word |
| rd_data_o | output | 32 | Registered readback word |
| irq_i | input | C | Common interrupt inputs |
| core_irq_o | output | N*C | Per-core, per-interrupt lines, bit k*C+i |

## Verification
Level inputs are held high across several cycles and dropped again, to separate combinational following from latching. Edge inputs are pulsed, held, masked and acknowledged, including an acknowledge in the same cycle as a fresh edge, to tell the pending flag's set and clear priority apart. Rotating delivery is driven with a sparse bitmask (cores 0, 1 and 3) over several successive assertions, which shows both the skip of a clear bit and the wrap. Empty bitmasks, the unused policy codes and writes with every mode bit set show the boundary encodings. A behavioural model in the bench predicts every output and readback bit in every cycle.

// File: rtl/cidu_pkg.sv
package cidu_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ENABLE   = 3'd1,
        OP_SET_DEST = 3'd2,
        OP_SET_MODE = 3'd3,
        OP_RD_MODE  = 3'd4,
        OP_SET_MASK = 3'd5,
        OP_ACK      = 3'd6,
        OP_RD_DEST  = 3'd7
    } cidu_op_e;

    localparam int          TRIG_BIT = 4;
    localparam logic [1:0]  POLICY_ROTATE = 2'd1;
endpackage

// File: rtl/cidu_rr_pick.sv
module cidu_rr_pick #(
    parameter int N  = 4,
    parameter int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand_i,
    input  logic [CW-1:0] last_i,
    output logic          hit_o,
    output logic [CW-1:0] sel_o
);
    // Scan from the farthest offset down, so the nearest set bit above last wins.
    always_comb begin
        hit_o = 1'b0;
        sel_o = '0;
        for (int off = N; off >= 1; off--) begin
            int idx;
            idx = int'(last_i) + off;
            if (idx >= N) idx = idx - N;
            if (cand_i[idx]) begin
                hit_o = 1'b1;
                sel_o = CW'(idx);
            end
        end
    end
endmodule

// File: rtl/cidu_slot.sv
module cidu_slot
    import cidu_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          irq_i,
    input  logic          wr_dest_i,
    input  logic          wr_mode_i,
    input  logic          wr_mask_i,
    input  logic          ack_i,
    input  logic [31:0]   wdata_i,
    output logic [N-1:0]  dest_o,
    output logic [31:0]   mode_o,
    output logic [N-1:0]  route_o
);
    typedef struct packed {
        logic [N-1:0]  dest;
        logic [1:0]    policy;
        logic          edge_mode;
        logic          masked;
        logic          pend;
        logic          prev;
        logic [CW-1:0] last;
        logic          live_prev;
    } slot_t;

    slot_t s_d, s_q;
    logic          rise, live, hit;
    logic [CW-1:0] sel;
    logic [N-1:0]  one_hot;

    cidu_rr_pick #(.N(N), .CW(CW)) u_pick (
        .cand_i (s_q.dest),
        .last_i (s_q.last),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    always_comb begin
        s_d     = s_q;
        rise    = irq_i & ~s_q.prev;
        live    = en_i & ~s_q.masked & (s_q.edge_mode ? s_q.pend : irq_i);
        one_hot = '0;
        if (hit) one_hot[sel] = 1'b1;
        if (!live)                            route_o = '0;
        else if (s_q.policy == POLICY_ROTATE) route_o = one_hot;
        else                                  route_o = s_q.dest;

        s_d.prev      = irq_i;
        s_d.live_prev = live;
        s_d.pend      = s_q.edge_mode & ((s_q.pend & ~ack_i) | rise);
        if (s_q.live_prev && !live && hit) s_d.last = sel;
        if (wr_dest_i) s_d.dest = wdata_i[N-1:0];
        if (wr_mode_i) begin
            s_d.policy    = wdata_i[1:0];
            s_d.edge_mode = wdata_i[TRIG_BIT];
        end
        if (wr_mask_i) s_d.masked = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.masked    <= 1'b1;
            s_q.last      <= CW'(N - 1);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        mode_o           = '0;
        mode_o[1:0]      = s_q.policy;
        mode_o[TRIG_BIT] = s_q.edge_mode;
    end
    assign dest_o = s_q.dest;

    // R9
    rotate_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.policy == POLICY_ROTATE) |-> $onehot0(route_o));
    // R10
    empty_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.dest == '0) |-> (route_o == '0));
    // R7
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.edge_mode && irq_i && !s_q.prev) |=> s_q.pend);
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(irq_i && !s_q.prev)) |=> !s_q.pend);
    // R8
    fixed_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.policy != POLICY_ROTATE && route_o != '0) |-> (route_o == s_q.dest));
endmodule

// File: rtl/cidu_top.sv
module cidu_top
    import cidu_pkg::*;
#(
    parameter int C     = 4,
    parameter int N     = 4,
    parameter int IDX_W = (C > 1) ? $clog2(C) : 1,
    parameter int CW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [IDX_W-1:0] cmd_idx_i,
    input  logic [31:0]      cmd_data_i,
    output logic [31:0]      rd_data_o,
    input  logic [C-1:0]     irq_i,
    output logic [N*C-1:0]   core_irq_o
);
    typedef struct packed {
        logic        en;
        logic [31:0] rd;
    } top_t;

    top_t t_d, t_q;
    cidu_op_e op;
    logic     idx_ok;

    logic [C-1:0] wr_dest, wr_mode, wr_mask, ack;
    logic [N-1:0] dest_w  [C];
    logic [31:0]  mode_w  [C];
    logic [N-1:0] route_w [C];

    always_comb begin
        op      = cidu_op_e'(cmd_op_i);
        idx_ok  = int'(cmd_idx_i) < C;
        t_d     = t_q;
        wr_dest = '0;
        wr_mode = '0;
        wr_mask = '0;
        ack     = '0;
        if (cmd_valid_i) begin
            if (op == OP_ENABLE) t_d.en = cmd_data_i[0];
            if (idx_ok) begin
                case (op)
                    OP_SET_DEST: wr_dest[cmd_idx_i] = 1'b1;
                    OP_SET_MODE: wr_mode[cmd_idx_i] = 1'b1;
                    OP_SET_MASK: wr_mask[cmd_idx_i] = 1'b1;
                    OP_ACK:      ack[cmd_idx_i]     = 1'b1;
                    OP_RD_MODE:  t_d.rd = mode_w[cmd_idx_i];
                    OP_RD_DEST:  t_d.rd = 32'(dest_w[cmd_idx_i]);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    for (genvar i = 0; i < C; i++) begin : g_slot
        cidu_slot #(.N(N), .CW(CW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (t_q.en),
            .irq_i     (irq_i[i]),
            .wr_dest_i (wr_dest[i]),
            .wr_mode_i (wr_mode[i]),
            .wr_mask_i (wr_mask[i]),
            .ack_i     (ack[i]),
            .wdata_i   (cmd_data_i),
            .dest_o    (dest_w[i]),
            .mode_o    (mode_w[i]),
            .route_o   (route_w[i])
        );
        for (genvar k = 0; k < N; k++) begin : g_core
            assign core_irq_o[k*C + i] = route_w[i][k];
        end
    end

    assign rd_data_o = t_q.rd;

    // R2
    idle_until_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !t_q.en |-> (core_irq_o == '0));
    // R4
    mode_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == 3'd4) |=> (rd_data_o[31:5] == '0 && rd_data_o[3:2] == '0));
endmodule

// File: tb/cidu_top_bench.sv
`timescale 1ns/1ps
module cidu_top_bench;
    localparam int C = 4;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [2:0]  cmd_op_i = '0;
    logic [1:0]  cmd_idx_i = '0;
    logic [31:0] cmd_data_i = '0;
    logic [31:0] rd_data_o;
    logic [C-1:0] irq_i = '0;
    logic [N*C-1:0] core_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string req = "R1";

    // behavioural model state
    int m_en, m_rd;
    int m_mask[C], m_dest[C], m_pol[C], m_edge[C], m_pend[C], m_prev[C], m_last[C], m_lprev[C];

    always #2 clk = ~clk;

    cidu_top #(.C(C), .N(N)) u_cidu_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_idx_i(cmd_idx_i), .cmd_data_i(cmd_data_i), .rd_data_o(rd_data_o),
        .irq_i(irq_i), .core_irq_o(core_irq_o)
    );

    function automatic int m_live(int i);
        if (m_en == 0 || m_mask[i] != 0) return 0;
        return m_edge[i] != 0 ? m_pend[i] : int'(irq_i[i]);
    endfunction

    function automatic int m_target(int i);
        for (int off = 1; off <= N; off++) begin
            int c = (m_last[i] + off) % N;
            if (((m_dest[i] >> c) & 1) != 0) return c;
        end
        return -1;
    endfunction

    function automatic logic [N*C-1:0] m_out();
        logic [N*C-1:0] o = '0;
        for (int i = 0; i < C; i++) begin
            if (m_live(i) != 0) begin
                if (m_pol[i] == 1) begin
                    if (m_target(i) >= 0) o[m_target(i)*C + i] = 1'b1;
                end else begin
                    for (int k = 0; k < N; k++)
                        if (((m_dest[i] >> k) & 1) != 0) o[k*C + i] = 1'b1;
                end
            end
        end
        return o;
    endfunction

    task automatic m_reset();
        m_en = 0; m_rd = 0;
        for (int i = 0; i < C; i++) begin
            m_mask[i] = 1; m_dest[i] = 0; m_pol[i] = 0; m_edge[i] = 0;
            m_pend[i] = 0; m_prev[i] = 0; m_last[i] = N - 1; m_lprev[i] = 0;
        end
    endtask

    task automatic m_step();
        int live[C], tgt[C];
        int i0 = int'(cmd_idx_i);
        for (int i = 0; i < C; i++) begin
            live[i] = m_live(i);
            tgt[i]  = m_target(i);
        end
        for (int i = 0; i < C; i++) begin
            int ackd = (cmd_valid_i && cmd_op_i == 3'd6 && i0 == i) ? 1 : 0;
            int rise = (irq_i[i] && m_prev[i] == 0) ? 1 : 0;
            if (m_edge[i] != 0) m_pend[i] = ((m_pend[i] != 0 && ackd == 0) || rise != 0) ? 1 : 0;
            else                m_pend[i] = 0;
            if (m_lprev[i] != 0 && live[i] == 0 && tgt[i] >= 0) m_last[i] = tgt[i];
            m_lprev[i] = live[i];
            m_prev[i]  = int'(irq_i[i]);
        end
        if (cmd_valid_i) begin
            case (cmd_op_i)
                3'd1: m_en = int'(cmd_data_i[0]);
                3'd2: m_dest[i0] = int'(cmd_data_i[N-1:0]);
                3'd3: begin m_pol[i0] = int'(cmd_data_i[1:0]); m_edge[i0] = int'(cmd_data_i[4]); end
                3'd4: m_rd = m_pol[i0] + 16 * m_edge[i0];
                3'd5: m_mask[i0] = int'(cmd_data_i[0]);
                3'd7: m_rd = m_dest[i0];
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        logic [N*C-1:0] eo = m_out();
        checks++;
        if (core_irq_o !== eo) begin
            fails++;
            $display("FAIL %s core_irq_o actual=%h expected=%h at %0t", req, core_irq_o, eo, $time);
        end
        checks++;
        if (rd_data_o !== 32'(m_rd)) begin
            fails++;
            $display("FAIL %s rd_data_o actual=%h expected=%h at %0t", req, rd_data_o, m_rd, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        m_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int j = 0; j < n; j++) tick();
    endtask

    task automatic cmd(logic [2:0] op, int idx, logic [31:0] data);
        cmd_valid_i = 1'b1; cmd_op_i = op; cmd_idx_i = 2'(idx); cmd_data_i = data;
        tick();
        cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_data_i = '0;
    endtask

    task automatic expect_rd(logic [31:0] v);
        checks++;
        if (rd_data_o !== v) begin
            fails++;
            $display("FAIL %s rd_data_o actual=%h expected=%h", req, rd_data_o, v);
        end
    endtask

    task automatic pulse(int i, int hi, int lo);
        irq_i[i] = 1'b1; idle(hi);
        irq_i[i] = 1'b0; idle(lo);
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req = "R1"; idle(2);
        cmd(3'd4, 2, 0); expect_rd(32'h0);
        cmd(3'd7, 3, 0); expect_rd(32'h0);

        req = "R2";
        cmd(3'd2, 0, 32'h3);
        cmd(3'd5, 0, 32'h0);
        irq_i[0] = 1'b1; idle(3);
        cmd(3'd1, 0, 32'h1);
        idle(2);

        req = "R6"; irq_i[0] = 1'b0; idle(2); irq_i[0] = 1'b1; idle(2); irq_i[0] = 1'b0; idle(1);

        req = "R3"; cmd(3'd2, 2, 32'h4); cmd(3'd7, 2, 0); expect_rd(32'h4);
        cmd(3'd2, 1, 32'hFFFF_FFF9); cmd(3'd7, 1, 0); expect_rd(32'h9);
        req = "R11"; cmd(3'd5, 2, 0); pulse(2, 3, 2);

        req = "R4"; cmd(3'd3, 3, 32'hFFFF_FFFF); cmd(3'd4, 3, 0); expect_rd(32'h13);
        cmd(3'd3, 3, 32'h0); cmd(3'd4, 3, 0); expect_rd(32'h0);

        req = "R7";
        cmd(3'd2, 3, 32'hA);
        cmd(3'd3, 3, 32'h10);
        cmd(3'd5, 3, 0);
        pulse(3, 1, 3);
        cmd(3'd6, 3, 0); idle(2);
        pulse(3, 4, 2);
        cmd(3'd6, 3, 0);
        irq_i[3] = 1'b1; cmd(3'd6, 3, 0); irq_i[3] = 1'b0; idle(3);
        cmd(3'd6, 3, 0); idle(1);

        req = "R5";
        cmd(3'd5, 3, 32'h1);
        pulse(3, 1, 3);
        cmd(3'd5, 3, 32'h0); idle(2);
        cmd(3'd6, 3, 0); idle(1);
        cmd(3'd5, 0, 32'h1); irq_i[0] = 1'b1; idle(2); irq_i[0] = 1'b0;
        cmd(3'd5, 0, 32'h0);

        req = "R9";
        cmd(3'd2, 1, 32'hB);
        cmd(3'd3, 1, 32'h1);
        cmd(3'd5, 1, 0);
        for (int r = 0; r < 5; r++) pulse(1, 2, 1);
        req = "R9"; cmd(3'd3, 1, 32'h11);
        for (int r = 0; r < 3; r++) begin pulse(1, 1, 2); cmd(3'd6, 1, 0); idle(1); end

        req = "R8";
        cmd(3'd3, 1, 32'h2); pulse(1, 2, 1);
        cmd(3'd3, 1, 32'h3); pulse(1, 2, 1);
        cmd(3'd3, 1, 32'h0); pulse(1, 2, 1);

        req = "R10";
        cmd(3'd2, 1, 32'h0); pulse(1, 2, 1);
        cmd(3'd3, 1, 32'h1); pulse(1, 2, 1);

        req = "R2"; cmd(3'd2, 0, 32'hF); cmd(3'd1, 0, 32'h0); pulse(0, 2, 1);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule